// File: doc/BRIEF.md
# DRAM Refresh Timer and Scheduler

This block keeps a two-bank, two-byte-lane DRAM array refreshed. It counts crystal clock periods and raises a refresh request once per programmed interval. When the DRAM cycle sequencer reports that the row and column strobes are free, it runs one CAS-before-RAS refresh on every bank and every byte lane at once. Software sets the interval through an 8-bit rate field N. The interval is (N+1) x 16 clocks, so it spans 16 to 4096 clocks in steps of 16.

The timer and its rate register have no reset. Refreshes keep running while reset is asserted. Writing the rate field restarts the interval and requests a refresh at once. The rate field can be read at any time without disturbing the count.

Refresh and bus arbitration are interlocked. The external bus grant is held back while a refresh runs. If a grant or grant acknowledge is seen before a refresh starts, no refresh starts until the bus comes back. The timer keeps counting in the meantime, so a refresh may be waiting when the bus returns.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After a write of N, the timer raises a refresh request every (N+1)*16 clock cycles, counted from the write edge. N is an unsigned 8-bit value.
- R2: The clock edge that takes a rate write sets the refresh request (ref_req_o = 1) and restarts the interval.
- R3: cfg_rdata_o always shows the last value written, and observing it has no effect on the timer.
- R4: rst_ni has no effect on the timer, on the rate value or on the strobe sequence, and refreshes continue while rst_ni is low.
- R5: A refresh starts only on an edge where ref_req_o and dram_free_i are both high and no refresh is running. Otherwise the request stays pending.
- R6: The strobe sequence is as follows. CAS goes low for one cycle with RAS high. RAS then goes low with CAS for 2 cycles. Both return high together for one precharge cycle. ref_done_o then pulses high for one cycle. Strobes are active-low.
- R7: All RAS lines and all CAS lines switch together in every cycle.
- R8: Requests that arrive while one is pending merge into it, so a pending request yields exactly one refresh.
- R9: While a refresh runs, and in the cycle after it, ext_bg_o stays low even if cpu_bg_i is high. It rises the cycle after that.
- R10: No refresh starts on an edge where cpu_bg_i or ext_bgack_i is high. The pending request is kept and is served once both are low.
- R11: Outside refresh, ext_bg_o follows cpu_bg_i one cycle later. ext_bg_o is forced low while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Active-low async reset (grant path only) |
| cfg_wr_i | input | 1 | Rate field write strobe |
| cfg_wdata_i | input | 8 | Rate value N to write |
| cfg_rdata_o | output | 8 | Current rate value |
| dram_free_i | input | 1 | Strobes free of normal DRAM access this cycle |
| ref_req_o | output | 1 | Refresh pending |
| ref_done_o | output | 1 | One-cycle pulse after the precharge cycle |
| cpu_bg_i | input | 1 | Internal bus grant from the core |
| ext_bgack_i | input | 1 | Grant acknowledge from another master |
| ext_bg_o | output | 1 | External bus grant |
| ras_n_o | output | 2 | Per-bank row strobe, active low |
| cas_n_o | output | 2 | Per-lane column strobe, active low |

## Verification
A wrong prescaler or down-counter value shows up as a refresh whose CAS falls early or late against the (N+1)*16 schedule. This is seen at the next request, which is at most one interval away. A sequencer stuck in a wrong state shows on the strobes within one or two cycles, either as RAS without CAS or as a missing done pulse. A wrong pending flag shows as either an extra refresh or a missed refresh once the DRAM is free again. A lapse in the grant interlock shows on ext_bg_o in the same cycle as the strobes.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAS  = 2'd1,
    ST_RAS  = 2'd2,
    ST_PRE  = 2'd3
  } ref_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PRE_W  = 4,
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RATE_W-1:0] wdata_i,
  input  logic              start_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              pend_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [RATE_W-1:0] cnt_q, rate_q;
  logic              pend_q;
  logic              tick, expire;

  assign tick   = &pre_q;
  assign expire = tick && (cnt_q == '0);

  // No reset: the interval survives every reset
  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      rate_q <= wdata_i;
      pre_q  <= '0;
      cnt_q  <= wdata_i;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) cnt_q <= expire ? rate_q : cnt_q - 1'b1;
    end
    pend_q <= (pend_q && !start_i) || expire || wr_i;
  end

  assign rate_o = rate_q;
  assign pend_o = pend_q;

  a_r2_write_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_q);
  a_r1_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> cnt_q <= rate_q);
endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int NUM_LANES = 2,
  parameter int RAS_HOLD  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 active_o,
  output logic                 done_o,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_LANES-1:0] cas_n_o
);
  localparam int HOLD_W = $clog2(RAS_HOLD + 1);

  ref_state_e        st_q, st_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              done_q, cas_on_d, ras_on_d;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CAS;
      ST_CAS: begin
        st_d   = ST_RAS;
        hold_d = HOLD_W'(RAS_HOLD - 1);
      end
      ST_RAS: begin
        if (hold_q == '0) st_d = ST_PRE;
        else hold_d = hold_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cas_on_d = (st_d == ST_CAS) || (st_d == ST_RAS);
  assign ras_on_d = (st_d == ST_RAS);

  // Sequencer runs through reset by design
  always_ff @(posedge clk_i) begin
    st_q   <= st_d;
    hold_q <= hold_d;
    done_q <= (st_q == ST_PRE);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic ras_n_q;
    always_ff @(posedge clk_i) ras_n_q <= !ras_on_d;
    assign ras_n_o[b] = ras_n_q;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic cas_n_q;
    always_ff @(posedge clk_i) cas_n_q <= !cas_on_d;
    assign cas_n_o[l] = cas_n_q;
  end

  assign active_o = (st_q != ST_IDLE);
  assign done_o   = done_q;

  a_r6_ras_inside_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o[0] |-> !cas_n_o[0]);
  a_r6_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o[0]) |-> $past(!cas_n_o[0]));
  a_r6_done_strobes_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ras_n_o[0] && cas_n_o[0]));
endmodule

// File: rtl/dram_ref_arb.sv
module dram_ref_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic free_i,
  input  logic active_i,
  input  logic bg_int_i,
  input  logic bgack_i,
  output logic start_o,
  output logic bg_o
);
  logic bg_q;

  // A grant seen first wins over a refresh
  assign start_o = pend_i && free_i && !active_i && !bg_int_i && !bgack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bg_q <= 1'b0;
    else         bg_q <= bg_int_i && !active_i;
  end

  assign bg_o = bg_q;

  a_r9_grant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> !bg_o);
  a_r11_grant_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && bg_int_i) |=> bg_o);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int PRE_W     = 4,
  parameter int RATE_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int NUM_LANES = 2,
  parameter int RAS_HOLD  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_wr_i,
  input  logic [RATE_W-1:0]    cfg_wdata_i,
  output logic [RATE_W-1:0]    cfg_rdata_o,
  input  logic                 dram_free_i,
  output logic                 ref_req_o,
  output logic                 ref_done_o,
  input  logic                 cpu_bg_i,
  input  logic                 ext_bgack_i,
  output logic                 ext_bg_o,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_LANES-1:0] cas_n_o
);
  logic pend, start, active;

  dram_ref_timer #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .start_i (start),
    .rate_o  (cfg_rdata_o),
    .pend_o  (pend)
  );

  dram_ref_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .free_i   (dram_free_i),
    .active_i (active),
    .bg_int_i (cpu_bg_i),
    .bgack_i  (ext_bgack_i),
    .start_o  (start),
    .bg_o     (ext_bg_o)
  );

  dram_ref_seq #(.NUM_BANKS(NUM_BANKS), .NUM_LANES(NUM_LANES), .RAS_HOLD(RAS_HOLD)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .active_o (active),
    .done_o   (ref_done_o),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o)
  );

  assign ref_req_o = pend;

  a_r5_start_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o[0]) |-> $past(dram_free_i && ref_req_o));
  a_r10_no_start_on_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o[0]) |-> $past(!cpu_bg_i && !ext_bgack_i));
endmodule

// File: tb/sim_dram_refresh_ctrl.sv
module sim_dram_refresh_ctrl;
  localparam int NB = 2;
  localparam int NL = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, wr = 1'b0, gnt = 1'b0, bgi = 1'b0, bga = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          req, done, bgo;
  logic [NB-1:0] ras_n;
  logic [NL-1:0] cas_n;

  int checks = 0, errors = 0, cyc = 0;
  bit armed = 0, m_tarm = 0, m_pend = 0, m_done = 0, m_bg = 0;
  int m_phase = 0, m_wcyc = 0, m_per = 16;
  logic [7:0] m_rate = '0;
  int n_falls = 0, last_fall = 0, last_gap = 0;
  bit prev_cas = 1;

  dram_refresh_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .dram_free_i(gnt), .ref_req_o(req), .ref_done_o(done),
    .cpu_bg_i(bgi), .ext_bgack_i(bga), .ext_bg_o(bgo), .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit w, logic [7:0] n, bit g, bit bi, bit ba, bit r);
    bit e_cas, e_ras, req_evt, start;
    @(negedge clk);
    if (armed) begin
      e_cas = !(m_phase >= 1 && m_phase <= 3);
      e_ras = !(m_phase == 2 || m_phase == 3);
      chk(cas_n == {NL{e_cas}}, "R5 R6 R7 cas", cas_n, {NL{e_cas}});
      chk(ras_n == {NB{e_ras}}, "R4 R6 R7 ras", ras_n, {NB{e_ras}});
      chk(req == m_pend, "R1 R2 R8 req", req, m_pend);
      chk(done == m_done, "R6 done", done, m_done);
      chk(bgo == m_bg, "R9 R11 bg", bgo, m_bg);
      chk(rdata == m_rate, "R3 rdata", rdata, m_rate);
      if (prev_cas && !cas_n[0]) begin
        n_falls++;
        last_gap  = cyc - last_fall;
        last_fall = cyc;
      end
    end
    prev_cas = cas_n[0];
    wr = w; wdata = n; gnt = g; bgi = bi; bga = ba; rst_n = r;
    req_evt = m_tarm && !w && (((cyc - m_wcyc) % m_per) == 0);
    start   = (m_phase == 0) && m_pend && g && !bi && !ba;
    m_bg    = r && bi && (m_phase == 0);
    m_done  = (m_phase == 4);
    m_pend  = (m_pend && !start) || req_evt || w;
    if (start) m_phase = 1;
    else if (m_phase == 4) m_phase = 0;
    else if (m_phase != 0) m_phase++;
    if (w) begin
      m_wcyc = cyc; m_per = (int'(n) + 1) * 16; m_tarm = 1; m_rate = n; armed = 1;
    end
    cyc++;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0, bg_left;
    bit r_cur;
    void'($urandom(32'h5eed));
    // R4: program and refresh under reset
    step(1, 8'd2, 1, 0, 0, 0);
    for (int i = 0; i < 150; i++) step(0, 8'd0, 1, 0, 0, 0);
    chk(n_falls >= 3, "R4 refresh under reset", n_falls, 3);
    for (int i = 0; i < 5; i++) step(0, 8'd0, 1, 1, 0, 0);
    chk(bgo == 0, "R11 reset forces grant low", bgo, 0);
    chk(rdata == 8'd2, "R3 R4 rate kept in reset", rdata, 2);
    // R1: interval length
    step(1, 8'd3, 1, 0, 0, 1);
    for (int i = 0; i < 300; i++) step(0, 8'd0, 1, 0, 0, 1);
    chk(last_gap == 64, "R1 interval N=3", last_gap, 64);
    // R8: merge while strobes busy
    step(1, 8'd0, 0, 0, 0, 1);
    for (int i = 0; i < 100; i++) step(0, 8'd0, 0, 0, 0, 1);
    f0 = n_falls;
    for (int i = 0; i < 8; i++) step(0, 8'd0, 1, 0, 0, 1);
    chk(n_falls - f0 == 1, "R8 merged refreshes", n_falls - f0, 1);
    // R10: bus away suppresses refresh, R11 grant passes
    f0 = n_falls;
    step(1, 8'd0, 1, 1, 0, 1);
    for (int i = 0; i < 100; i++) step(0, 8'd0, 1, 1, 0, 1);
    chk(n_falls == f0, "R10 no refresh while bus away", n_falls - f0, 0);
    chk(bgo == 1, "R11 grant passes", bgo, 1);
    for (int i = 0; i < 8; i++) step(0, 8'd0, 1, 0, 0, 1);
    chk(n_falls - f0 == 1, "R10 pending served on return", n_falls - f0, 1);
    // R9: grant raised mid-refresh
    step(1, 8'd0, 1, 0, 0, 1);
    step(0, 8'd0, 1, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 8'd0, 1, 1, 0, 1);
    chk(bgo == 0 && ras_n == '0, "R9 grant held during refresh", bgo, 0);
    for (int i = 0; i < 4; i++) step(0, 8'd0, 1, 1, 0, 1);
    chk(bgo == 1, "R9 grant after refresh", bgo, 1);
    // Random mix
    bg_left = 0; r_cur = 1;
    for (int i = 0; i < 4000; i++) begin
      bit w, g, ba;
      logic [7:0] n;
      w = ($urandom % 300) == 0;
      n = 8'($urandom % 8);
      g = ($urandom % 4) != 0;
      ba = ($urandom % 50) == 0;
      if (bg_left > 0) bg_left--;
      else if (($urandom % 200) == 0) bg_left = 1 + int'($urandom % 60);
      if (($urandom % 500) == 0) r_cur = 0;
      else if (!r_cur && ($urandom % 6) == 0) r_cur = 1;
      step(w, n, g, bg_left > 0, ba, r_cur);
    end
    for (int i = 0; i < 20; i++) step(0, 8'd0, 1, 0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule